// File: doc/BRIEF.md
# Host Reset Pulse Generator

This block turns a one-cycle reset request into a timed reset pulse toward a host chipset. Each request carries a select bit that chooses between two kinds of reset. A cold reset pulls the system power-good output low for a fixed time and then lets it follow its source level again. This forces the chipset through a full power cycle. A warm reset drives the active-low reset-request line low for a shorter fixed time, and power stays up.

The reset-request line acts as an emulated open-drain pin. Its data value is held at zero at all times. Only the output enable changes: it is high while the pulse runs and low otherwise, so at all other times the pad floats and an external pull-up holds the line high. Power-good passes through the block: the output equals the power-good input, except while a cold pulse forces it low. A cold request that arrives while the power-good input is already low has nothing to drop, so the block discards it. A control FSM with three states (`ST_IDLE`, `ST_COLD`, `ST_WARM`) and one down-counter carry out all of this.

The FSM moves between states on these named transitions:
- `ACCEPT_COLD`: from `ST_IDLE` to `ST_COLD`, on a request with cold selected and power-good high.
- `ACCEPT_WARM`: from `ST_IDLE` to `ST_WARM`, on a request with cold not selected.
- `COLD_DONE`: from `ST_COLD` to `ST_IDLE`, when the counter reaches zero.
- `WARM_DONE`: from `ST_WARM` to `ST_IDLE`, when the counter reaches zero.

Any other input leaves the state unchanged.

Top module: `host_reset_pulser`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `busy_o` is 0, `rst_req_oe_o` is 0, and `pgood_o` equals `pgood_i`.
- R2: A request with `cold_sel_i`=1 while `pgood_i`=1 and the block is idle drives `pgood_o` low for exactly COLD_CYC clock cycles. The pulse starts in the cycle after the request, and then `pgood_o` follows `pgood_i` again. COLD_CYC = ceil(CLK_HZ·COLD_US/10^6), which is 10000 at the defaults.
- R3: A cold request made while `pgood_i`=0 is discarded: `busy_o` stays 0, no pulse follows, and `rst_req_oe_o` stays 0.
- R4: A request with `cold_sel_i`=0 while idle raises `rst_req_oe_o` for exactly WARM_CYC cycles, starting in the cycle after the request. WARM_CYC = ceil(CLK_HZ·WARM_US/10^6), which is 1000 at the defaults. `rst_req_o` is 0 in every cycle.
- R5: A warm pulse never changes `pgood_o`, which keeps following `pgood_i`. A cold pulse never raises `rst_req_oe_o`.
- R6: `busy_o` is 1 in exactly the cycles of a pulse. Requests that arrive while `busy_o` is 1 are discarded and cause no later pulse.
- R7: A request that arrives in the first cycle after `busy_o` falls is accepted, so the next pulse starts without a gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle reset request strobe |
| cold_sel_i | input | 1 | 1 selects a cold reset, 0 a warm reset |
| pgood_i | input | 1 | Current power-good level from the power sequencer |
| pgood_o | output | 1 | Power-good toward the chipset, forced low during a cold pulse |
| rst_req_oe_o | output | 1 | Output enable of the emulated open-drain reset-request pin |
| rst_req_o | output | 1 | Data value of the reset-request pin, always 0 |
| busy_o | output | 1 | High while a pulse is in progress |

## Verification
The assertions check several rules on every cycle:
- The two pulse kinds never overlap.
- A warm pulse leaves power-good untouched.
- A cold request made while power-good is low never raises busy.
- An accepted request raises busy in the next cycle.
- A running pulse holds its state until the counter expires.
- The counter stays at zero once it gets there.

Some behaviour only the bench scenarios can show. These scenarios measure the exact pulse widths in cycles and the match between busy cycles and pulse cycles. They also confirm that a request discarded while busy never turns into a late pulse, and that a pulse can start straight after the previous one ends.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COLD = 2'd1,
        ST_WARM = 2'd2
    } hrp_state_e;

    // Round up so the pulse is never shorter than the requested duration.
    function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                     longint unsigned us);
        return (hz * us + 64'd999_999) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/hrp_timer.sv
module hrp_timer #(
    parameter int unsigned COLD_LEN = 10000,
    parameter int unsigned WARM_LEN = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_cold,
    input  logic load_warm,
    output logic expired
);
    localparam int unsigned MAX_LEN = (COLD_LEN > WARM_LEN) ? COLD_LEN : WARM_LEN;
    localparam int unsigned CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
    localparam logic [CNT_W-1:0] COLD_LOAD = CNT_W'(COLD_LEN - 1);
    localparam logic [CNT_W-1:0] WARM_LOAD = CNT_W'(WARM_LEN - 1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_cold) begin
            remain_q <= COLD_LOAD;
        end else if (load_warm) begin
            remain_q <= WARM_LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load_cold && !load_warm) |=> expired); // R2

    AST_TMR_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_cold && load_warm)); // R5

endmodule

// File: rtl/hrp_fsm.sv
module hrp_fsm
    import hrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cold_sel,
    input  logic pgood_in,
    input  logic expired,
    output logic load_cold,
    output logic load_warm,
    output logic busy,
    output logic drop_pgood,
    output logic drive_rst_req
);
    hrp_state_e state_q, state_d;

    logic accept_cold;
    logic accept_warm;

    // A cold request only makes sense while power-good is high.
    assign accept_cold = req && cold_sel && pgood_in;
    assign accept_warm = req && !cold_sel;

    // Next state
    always_comb begin
        state_d   = state_q;
        load_cold = 1'b0;
        load_warm = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_cold) begin
                    state_d   = ST_COLD;   // ACCEPT_COLD
                    load_cold = 1'b1;
                end else if (accept_warm) begin
                    state_d   = ST_WARM;   // ACCEPT_WARM
                    load_warm = 1'b1;
                end
            end
            ST_COLD: if (expired) state_d = ST_IDLE;  // COLD_DONE
            ST_WARM: if (expired) state_d = ST_IDLE;  // WARM_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy          = 1'b0;
        drop_pgood    = 1'b0;
        drive_rst_req = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COLD: begin
                busy       = 1'b1;
                drop_pgood = 1'b1;
            end
            ST_WARM: begin
                busy          = 1'b1;
                drive_rst_req = 1'b1;
            end
            default: ;
        endcase
    end

    AST_COLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLD && !expired) |=> (state_q == ST_COLD)); // R6

    AST_WARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM && !expired) |=> (state_q == ST_WARM)); // R6

    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cold || load_warm) |-> (state_q == ST_IDLE)); // R6

endmodule

// File: rtl/host_reset_pulser.sv
module host_reset_pulser #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned COLD_US = 100,
    parameter int unsigned WARM_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic cold_sel_i,
    input  logic pgood_i,
    output logic pgood_o,
    output logic rst_req_oe_o,
    output logic rst_req_o,
    output logic busy_o
);
    localparam int unsigned COLD_CYC = int'(hrp_pkg::us_to_cycles(CLK_HZ, COLD_US));
    localparam int unsigned WARM_CYC = int'(hrp_pkg::us_to_cycles(CLK_HZ, WARM_US));

    logic load_cold, load_warm, expired;
    logic drop_pgood, drive_rst_req;

    hrp_timer #(
        .COLD_LEN (COLD_CYC),
        .WARM_LEN (WARM_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cold (load_cold),
        .load_warm (load_warm),
        .expired   (expired)
    );

    hrp_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req_i),
        .cold_sel      (cold_sel_i),
        .pgood_in      (pgood_i),
        .expired       (expired),
        .load_cold     (load_cold),
        .load_warm     (load_warm),
        .busy          (busy_o),
        .drop_pgood    (drop_pgood),
        .drive_rst_req (drive_rst_req)
    );

    assign pgood_o      = pgood_i & ~drop_pgood;
    assign rst_req_oe_o = drive_rst_req;
    assign rst_req_o    = 1'b0;

    AST_WARM_KEEPS_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_oe_o |-> (pgood_o == pgood_i)); // R5

    AST_COLD_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood_i && !pgood_o) |-> !rst_req_oe_o); // R5

    AST_SKIP_LOW_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && cold_sel_i && !pgood_i) |=> !busy_o); // R3

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && (!cold_sel_i || pgood_i)) |=> busy_o); // R7

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rst_req_oe_o && (pgood_o == pgood_i))); // R1

endmodule

// File: tb/host_reset_pulser_tb.sv
module host_reset_pulser_tb;
    localparam int CLK_HZ  = 100_000_000;
    localparam int COLD_US = 100;
    localparam int WARM_US = 10;
    localparam int COLD_N  = (CLK_HZ / 1_000_000) * COLD_US;
    localparam int WARM_N  = (CLK_HZ / 1_000_000) * WARM_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic cold_sel = 1'b0;
    logic pgood_i = 1'b1;
    logic pgood_o, oe, rdat, busy;

    always #5 clk = ~clk;

    host_reset_pulser #(.CLK_HZ(CLK_HZ), .COLD_US(COLD_US), .WARM_US(WARM_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cold_sel_i(cold_sel),
        .pgood_i(pgood_i), .pgood_o(pgood_o), .rst_req_oe_o(oe),
        .rst_req_o(rdat), .busy_o(busy));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { bit is_cold; int len; } pulse_t;
    pulse_t exp_q[$];

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: called at a negedge; request is seen by exactly one posedge.
    task automatic issue(bit c, bit expect_accept);
        req = 1'b1;
        cold_sel = c;
        if (expect_accept) exp_q.push_back('{c, c ? COLD_N : WARM_N});
        @(negedge clk);
        req = 1'b0;
        #1;
    endtask

    task automatic wait_idle();
        while (busy) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Monitor: measures pulses and compares with the scoreboard queue.
    int  warm_run = 0, cold_run = 0, busy_run = 0;
    bit  rdat_bad = 1'b0, overlap = 1'b0;

    task automatic close_pulse(bit c, int len);
        pulse_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, c ? "R6 unexpected cold pulse" : "R6 unexpected warm pulse", len, 0);
        end else begin
            e = exp_q.pop_front();
            check(e.is_cold == c, "R5 pulse kind", int'(c), int'(e.is_cold));
            check(len == e.len, c ? "R2 cold width" : "R4 warm width", len, e.len);
        end
        check(busy_run == len, "R6 busy cycles equal pulse", busy_run, len);
        check(!rdat_bad, "R4 data value held 0", int'(rdat_bad), 0);
        check(!overlap, "R5 kinds never overlap", int'(overlap), 0);
        busy_run = 0; rdat_bad = 1'b0; overlap = 1'b0;
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (rdat !== 1'b0) rdat_bad = 1'b1;
            if (oe && pgood_i && !pgood_o) overlap = 1'b1;
            if (oe && (pgood_o !== pgood_i)) overlap = 1'b1;
            if (busy) busy_run++;
            if (oe) warm_run++;
            else if (warm_run > 0) begin close_pulse(1'b0, warm_run); warm_run = 0; end
            if (pgood_i && !pgood_o) cold_run++;
            else if (cold_run > 0) begin close_pulse(1'b1, cold_run); cold_run = 0; end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(!busy, "R1 busy in reset", int'(busy), 0);
        check(!oe, "R1 oe in reset", int'(oe), 0);
        check(pgood_o == pgood_i, "R1 pgood follows in reset", int'(pgood_o), int'(pgood_i));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(!busy && !oe, "R1 idle after release", int'(busy || oe), 0);

        // R4: warm pulse
        issue(1'b0, 1'b1);
        check(busy && oe, "R4 warm starts next cycle", int'(busy && oe), 1);
        check(pgood_o == 1'b1, "R5 warm keeps pgood", int'(pgood_o), 1);
        wait_idle();

        // R2: cold pulse
        @(negedge clk); #1;
        issue(1'b1, 1'b1);
        check(busy && !pgood_o && !oe, "R2 cold starts next cycle", int'(pgood_o), 0);
        wait_idle();
        check(pgood_o == 1'b1, "R2 pgood restored", int'(pgood_o), 1);

        // R3: cold request with power-good already low
        @(negedge clk);
        pgood_i = 1'b0;
        issue(1'b1, 1'b0);
        check(!busy, "R3 no busy when pgood low", int'(busy), 0);
        check(!oe, "R3 no line drive", int'(oe), 0);
        repeat (5) @(negedge clk);
        #1;
        check(!busy && !pgood_o, "R3 still idle", int'(busy), 0);
        @(negedge clk);
        pgood_i = 1'b1;
        #1;
        check(pgood_o, "R1 pgood follows input", int'(pgood_o), 1);

        // R6: cold request during a warm pulse is dropped
        @(negedge clk); #1;
        issue(1'b0, 1'b1);
        repeat (100) @(negedge clk);
        issue(1'b1, 1'b0);
        check(pgood_o, "R6 ignored cold during warm", int'(pgood_o), 1);
        // R5: pgood input drop mid warm pulse passes through
        @(negedge clk);
        pgood_i = 1'b0;
        #1;
        check(pgood_o == 1'b0, "R5 pgood tracks input during warm", int'(pgood_o), 0);
        @(negedge clk);
        pgood_i = 1'b1;
        #1;
        wait_idle();

        // R6: warm request during a cold pulse is dropped
        @(negedge clk); #1;
        issue(1'b1, 1'b1);
        repeat (200) @(negedge clk);
        issue(1'b0, 1'b0);
        check(!oe, "R6 ignored warm during cold", int'(oe), 0);
        wait_idle();

        // R7: back-to-back, request in the first idle cycle
        issue(1'b0, 1'b1);
        check(busy, "R7 accepted right after busy falls", int'(busy), 1);
        wait_idle();
        issue(1'b0, 1'b1);
        check(busy, "R7 second back-to-back", int'(busy), 1);
        wait_idle();

        repeat (50) @(negedge clk);
        #1;
        check(exp_q.size() == 0, "R6 all expected pulses seen", exp_q.size(), 0);
        check(!busy && !oe, "R6 no late pulse", int'(busy || oe), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule